// File: doc/BRIEF.md
# Synchronous SRAM Cycle Decoder

This block sits at the front of a pipelined burst synchronous SRAM and decides, on every rising clock edge, what kind of cycle the bus is presenting. It samples three chip enables, two active-low address strobes, an advance input and a group of write-enable inputs. From these it forms one cycle type: deselect, new read, new write, burst continuation or suspend. The two strobes qualify the chip enables differently. The controller strobe always starts a cycle. The processor strobe starts a cycle only while the master enable is active.

The write inputs are resolved in order of priority. A global write enable overrides everything else. Below it, a byte-write enable hands control to one enable per 9-bit lane of the 18-bit word. When no lane is selected the cycle is a read. The decoder drives per-lane write strobes into a small lane-split storage array. That array registers its read data, so a read word appears one clock after its address. The decoder also holds a read-active flag. The flag is combined with an asynchronous output enable to tell the pad logic when to drive the data bus. The word address is supplied on every cycle by burst logic outside this block.

Top module: `ssram_cycle_dec`

## Requirements
- R1: While reset is asserted, and until the first cycle is sampled after it, `cyc_type` is 0, `lane_we` is 0, `op_is_wr` is 0, `dq_drive` is 0 and `dout` is 0.
- R2: A low `strb_cpu_n` has no effect while `ce_main_n` is high. The cycle is then classified as if both strobes were high.
- R3: A cycle starts when `strb_ctl_n` is low, or when `strb_cpu_n` and `ce_main_n` are both low. With `ce_main_n`=0, `ce_hi`=1 and `ce_lo_n`=0, the start is a READ (`cyc_type`=1) or a WRITE (`cyc_type`=2). With any of these enables inactive it is a DESELECT (`cyc_type`=0), which also clears `op_is_wr`.
- R4: `gw_n`=0 writes both lanes (`lane_we`=2'b11), whatever `bwe_n` and `bw_n` are.
- R5: With `gw_n`=1 and `bwe_n`=0, lane i is written exactly when `bw_n[i]`=0. Lane i is bits [9i+8:9i] of `din` and `dout`. If no lane is selected, or if `gw_n` and `bwe_n` are both 1, the cycle is a read.
- R6: With no start, an operation in progress and `adv_n`=0, the cycle is a BURST (`cyc_type`=3). It keeps the operation kind in `op_is_wr`. A write burst writes the lanes chosen by R4/R5 at that edge. A read burst reads `addr`.
- R7: With no start, an operation in progress and `adv_n`=1, the cycle is a SUSPEND (`cyc_type`=4). The operation kind is kept, no lane is written and `dout` holds its value.
- R8: With no start and no operation in progress, the cycle stays a DESELECT.
- R9: `dout` shows the word at the `addr` sampled on a read or read-burst edge, starting right after that edge.
- R10: `dq_drive` is high exactly when a read operation is in progress and `oe_n` is low. It follows `oe_n` without waiting for a clock, and it drops right after the single edge that samples a deselect or a write.
- R11: `cyc_type`, `lane_we` and `op_is_wr` update on the edge that samples the cycle and describe that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, gated by `ce_main_n` |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 4 | Word address from the external burst logic |
| din | input | 18 | Write data, two 9-bit lanes |
| dout | output | 18 | Registered read data |
| dq_drive | output | 1 | Data bus drive qualifier |
| cyc_type | output | 3 | Last sampled cycle type (0 deselect, 1 read, 2 write, 3 burst, 4 suspend) |
| op_is_wr | output | 1 | Operation in progress is a write |
| lane_we | output | 2 | Lanes written at the last edge |

## Verification
The decoder stores only two bits of history: whether an operation is in progress and whether that operation is a write. If either bit is wrong, the next cycle without a start is misclassified. A lost operation shows a BURST or SUSPEND as a DESELECT. A flipped kind turns a read burst into lane writes. Either fault shows at `cyc_type`, `op_is_wr` or `dq_drive` on the edge that samples that cycle, and a write into the wrong lane surfaces at `dout` one edge after the word is read back. The bench compares every port after every edge and reads back every word that was written with a lane mask.

// File: rtl/ssram_dec_pkg.sv
`timescale 1ns/1ps
package ssram_dec_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL = 3'd0,
    CYC_READ  = 3'd1,
    CYC_WRITE = 3'd2,
    CYC_BURST = 3'd3,
    CYC_SUSP  = 3'd4
  } cyc_e;
endpackage

// File: rtl/ssram_we_decode.sv
`timescale 1ns/1ps
// Resolves the write-enable priority into per-lane strobes.
module ssram_we_decode #(
  parameter int LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_sel,
  output logic             is_wr
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Global enable wins; otherwise byte-write enable passes the lane enable.
    assign lane_sel[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
  end

  assign is_wr = |lane_sel;
endmodule

// File: rtl/ssram_cycle_fsm.sv
`timescale 1ns/1ps
// Cycle classification: next-state logic and registers.
module ssram_cycle_fsm
  import ssram_dec_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] lane_sel,
  input  logic             is_wr,
  output logic [LANES-1:0] we_now,
  output logic             rd_now,
  output cyc_e             cyc_q,
  output logic             op_wr_q,
  output logic [LANES-1:0] lane_we_q,
  output logic             rd_act_q
);
  logic start, sel;
  logic act_q, act_d, opwr_d, rdact_d;
  cyc_e cyc_d;

  assign start = ~strb_ctl_n | (~strb_cpu_n & ~ce_main_n);
  assign sel   = ~ce_main_n & ce_hi & ~ce_lo_n;

  always_comb begin
    act_d  = act_q;
    opwr_d = op_wr_q;
    cyc_d  = CYC_DESEL;
    we_now = '0;
    rd_now = 1'b0;
    if (start) begin
      if (sel) begin
        act_d  = 1'b1;
        opwr_d = is_wr;
        if (is_wr) begin
          cyc_d  = CYC_WRITE;
          we_now = lane_sel;
        end else begin
          cyc_d  = CYC_READ;
          rd_now = 1'b1;
        end
      end else begin
        act_d  = 1'b0;
        opwr_d = 1'b0;
      end
    end else if (act_q) begin
      if (!adv_n) begin
        cyc_d = CYC_BURST;
        if (op_wr_q) we_now = lane_sel;
        else         rd_now = 1'b1;
      end else begin
        cyc_d = CYC_SUSP;
      end
    end
    rdact_d = act_d & ~opwr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      op_wr_q   <= 1'b0;
      cyc_q     <= CYC_DESEL;
      lane_we_q <= '0;
      rd_act_q  <= 1'b0;
    end else begin
      act_q     <= act_d;
      op_wr_q   <= opwr_d;
      cyc_q     <= cyc_d;
      lane_we_q <= we_now;
      rd_act_q  <= rdact_d;
    end
  end

  // R2: processor strobe without master enable cannot start from idle
  p_cpu_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_ctl_n && ce_main_n && !act_q) |=> (cyc_q == CYC_DESEL && !rd_act_q));

  // R10: a deselect start stops bus drive after one edge
  p_single_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl_n && !ce_hi) |=> (!rd_act_q && cyc_q == CYC_DESEL && !op_wr_q));

  // R6: burst keeps the operation kind
  p_burst_keeps_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && strb_ctl_n && (strb_cpu_n || ce_main_n) && !adv_n)
    |=> (cyc_q == CYC_BURST && op_wr_q == $past(op_wr_q)));

  // R7: suspend writes nothing and keeps the operation kind
  p_suspend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && strb_ctl_n && (strb_cpu_n || ce_main_n) && adv_n)
    |=> (cyc_q == CYC_SUSP && lane_we_q == '0 && op_wr_q == $past(op_wr_q)));
endmodule

// File: rtl/ssram_lane_array.sv
`timescale 1ns/1ps
// Lane-split storage with a registered read port.
module ssram_lane_array #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic [LANES-1:0] we,
  input  logic             rd,
  output logic [DW-1:0]    dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem_l [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem_l[addr] <= din[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_q <= '0;
      else if (rd) rd_q <= mem_l[addr];
    end

    assign dout[g*LANE_W +: LANE_W] = rd_q;
  end

  // R7: output data changes only on a read edge
  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(dout));
endmodule

// File: rtl/ssram_cycle_dec.sv
`timescale 1ns/1ps
module ssram_cycle_dec
  import ssram_dec_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_main_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dq_drive,
  output logic [2:0]       cyc_type,
  output logic             op_is_wr,
  output logic [LANES-1:0] lane_we
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [LANES-1:0] lane_sel, we_now;
  logic             is_wr, rd_now, rd_act_q;
  cyc_e             cyc_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ssram_we_decode #(.LANES(LANES)) i_we_dec (
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .lane_sel (lane_sel),
    .is_wr    (is_wr)
  );

  ssram_cycle_fsm #(.LANES(LANES)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ce_main_n  (ce_main_n),
    .ce_hi      (ce_hi),
    .ce_lo_n    (ce_lo_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .lane_sel   (lane_sel),
    .is_wr      (is_wr),
    .we_now     (we_now),
    .rd_now     (rd_now),
    .cyc_q      (cyc_q),
    .op_wr_q    (op_is_wr),
    .lane_we_q  (lane_we),
    .rd_act_q   (rd_act_q)
  );

  ssram_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_array (
    .clk   (clk),
    .rst_n (rst_n_s),
    .addr  (addr),
    .din   (din),
    .we    (we_now),
    .rd    (rd_now),
    .dout  (dout)
  );

  assign cyc_type = cyc_q;
  assign dq_drive = rd_act_q & ~oe_n;

  // R4: a selected start with global write writes every lane
  p_global_write_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!strb_ctl_n && !ce_main_n && ce_hi && !ce_lo_n && !gw_n)
    |=> (lane_we == {LANES{1'b1}} && op_is_wr));

  // R10: the bus is driven only during a read operation
  p_drive_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    dq_drive |-> (!op_is_wr && cyc_type != 3'd0 && cyc_type != 3'd2));
endmodule

// File: tb/test_ssram_cycle_dec.sv
`timescale 1ns/1ps
module test_ssram_cycle_dec;
  localparam int LANES = 2, LANE_W = 9, DEPTH = 16, AW = 4, DW = 18;

  logic clk, rst_n;
  logic ce_main_n, ce_hi, ce_lo_n, strb_cpu_n, strb_ctl_n, adv_n;
  logic gw_n, bwe_n, oe_n;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dq_drive, op_is_wr;
  logic [2:0]    cyc_type;
  logic [1:0]    lane_we;

  int n_chk = 0, n_err = 0;

  // bench model state
  bit            m_act, m_opwr;
  logic [DW-1:0] m_dout;
  logic [DW-1:0] mem [DEPTH];

  ssram_cycle_dec i_ssram_cycle_dec (
    .clk(clk), .rst_n(rst_n), .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
    .dq_drive(dq_drive), .cyc_type(cyc_type), .op_is_wr(op_is_wr), .lane_we(lane_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lanes_of(bit gw, bit bwe, logic [1:0] bw);
    if (!gw)       return 2'b11;
    else if (!bwe) return ~bw;
    else           return 2'b00;
  endfunction

  task automatic drive(bit cm, bit ch, bit cl, bit sp, bit sc, bit ad,
                       bit gw, bit bwe, logic [1:0] bw, bit oe,
                       logic [AW-1:0] a, logic [DW-1:0] d);
    bit start, sel, rd;
    logic [1:0] ln, e_we;
    logic [2:0] e_cyc;
    string ttag, ltag;
    @(negedge clk);
    ce_main_n = cm; ce_hi = ch; ce_lo_n = cl; strb_cpu_n = sp; strb_ctl_n = sc;
    adv_n = ad; gw_n = gw; bwe_n = bwe; bw_n = bw; oe_n = oe; addr = a; din = d;
    @(posedge clk);
    start = !sc || (!sp && !cm);
    sel   = !cm && ch && !cl;
    ln    = lanes_of(gw, bwe, bw);
    e_we  = 2'b00; rd = 1'b0; e_cyc = 3'd0;
    ltag  = gw ? "R5 lane strobes" : "R4 lane strobes";
    if (start) begin
      ttag = "R3 start type";
      if (sel) begin
        m_act = 1'b1; m_opwr = (ln != 2'b00);
        if (m_opwr) begin e_cyc = 3'd2; e_we = ln; end
        else begin e_cyc = 3'd1; rd = 1'b1; end
      end else begin
        m_act = 1'b0; m_opwr = 1'b0;
      end
    end else if (m_act) begin
      if (!ad) begin
        ttag = "R6 burst type"; e_cyc = 3'd3;
        if (m_opwr) e_we = ln; else rd = 1'b1;
      end else begin
        ttag = "R7 suspend type"; e_cyc = 3'd4;
      end
    end else begin
      ttag = "R8 idle type";
    end
    if (!sp && cm && sc) ttag = "R2 cpu strobe ignored";
    if (rd) m_dout = mem[a];
    for (int i = 0; i < LANES; i++)
      if (e_we[i]) mem[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    #2;
    chk(ttag, 32'(cyc_type), 32'(e_cyc));
    chk(ltag, 32'(lane_we), 32'(e_we));
    chk("R11 op kind", 32'(op_is_wr), 32'(m_opwr));
    chk("R9 read data", 32'(dout), 32'(m_dout));
    chk("R10 bus drive", 32'(dq_drive), 32'(m_act && !m_opwr && !oe));
  endtask

  // idle inputs: both strobes high, advance high
  task automatic idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, '0, '0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_act = 1'b0; m_opwr = 1'b0; m_dout = '0;
    rst_n = 1'b0;
    ce_main_n = 1'b1; ce_hi = 1'b0; ce_lo_n = 1'b1; strb_cpu_n = 1'b1; strb_ctl_n = 1'b1;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset type", 32'(cyc_type), 32'd0);
    chk("R1 reset lanes", 32'(lane_we), 32'd0);
    chk("R1 reset op", 32'(op_is_wr), 32'd0);
    chk("R1 reset drive", 32'(dq_drive), 32'd0);
    chk("R1 reset data", 32'(dout), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle();

    // R4: global write of every word, byte inputs inactive
    for (int i = 0; i < DEPTH; i++)
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1, 4'(i), 18'($urandom));
    // R3/R9: read start, then R10 asynchronous output enable
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd3, '0);
    @(negedge clk);
    oe_n = 1'b1; #1 chk("R10 async oe off", 32'(dq_drive), 32'd0);
    oe_n = 1'b0; #1 chk("R10 async oe on", 32'(dq_drive), 32'd1);
    // R6 read burst, R7 suspend holds data
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'd4, '0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 4'd9, '0);
    // R2: blocked processor strobe while reading -> burst continues
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'd5, '0);
    // R3/R10: controller strobe with secondary enable off -> deselect
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd0, '0);
    // R2/R8: blocked processor strobe while deselected
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'd1, '0);
    // R5: lane 0 only, then read back
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 4'd5, 18'h2A5A5);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd5, '0);
    // R5: byte-write enable with no lane -> read
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 4'd6, '0);
    // R6: write burst on lane 1, R7 write suspend
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 4'd6, 18'h1C3F0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 4'd7, 18'h3F00F);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 4'd8, 18'h00FFF);
    // R3: processor strobe start with master enabled, read back
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd6, '0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 4'd7, '0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 4'd8, '0);

    // constrained random mix
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 4) == 0, $urandom_range(0, 6) != 0, $urandom_range(0, 6) == 0,
            $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0, $urandom_range(0, 4) >= 3,
            $urandom_range(0, 4) != 0, $urandom_range(0, 4) >= 3, 2'($urandom),
            $urandom_range(0, 3) == 0, 4'($urandom), 18'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule